// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from a transmit handshake and shifts them out on the data-out pin, and it shifts the data-in pin back into receive words. One 32-bit control word sets its behaviour: the word length, the clock polarity and phase, the level the data-out line rests at, the bit order, an internal loopback path, and separate switches that turn off the transmitter and the receiver. A baud reload value sets the serial clock rate. Each half period of the serial clock lasts `baud_i + 1` system clock cycles, so the bit rate is the system clock divided by 2 and then by `baud_i + 1`.

A one-word holding register sits in front of the shift register. While a word shifts out, the next word can be accepted. A queued word starts on the same cycle as the final clock edge of the word before it, so the serial clock has no gap between words. The control word and the reload value are captured when each word starts. The `busy_o` output stays high while any word is queued or still shifting. It falls only with the final serial clock edge of the last word. Chip select, FIFOs and register access belong to neighbouring blocks.

Top module: `spi_shift_engine`

## Requirements
- R1: The word length L is taken from control bits 20:16, which hold L-1. Every word carries exactly L bits, giving 2L serial clock edges. For received words, bits L and above of `rx_data_o` are zero. The lengths 2 to 8, 16 and 32 must work.
- R2: Every serial clock half period inside a burst lasts exactly `baud_i + 1` system clock cycles.
- R3: Control bit 6 is the clock polarity. `sclk_o` rests at that level whenever no word is shifting, and it returns to that level after the final edge of a word.
- R4: Control bit 5 set selects phase 0. In phase 0, data changes on trailing edges and is sampled on leading edges, with the first bit on `mosi_o` before the first edge. Bit 5 clear selects phase 1. In phase 1, data changes on leading edges and is sampled on trailing edges.
- R5: Control bit 4 set sends and receives the most significant bit first. Bit 4 clear sends and receives the least significant bit first.
- R6: Control bit 7 set feeds the engine's own `mosi_o` to its receiver, and `miso_i` is then ignored.
- R7: Control bit 23 is the idle level of `mosi_o`, driven whenever no data bit is being presented. With control bit 0 set (transmitter off), words are still started by the transmit handshake, but `mosi_o` stays at the idle level for the whole word.
- R8: With control bit 1 set (receiver off), words shift but `rx_valid_o` never pulses.
- R9: With both control bits 0 and 1 set, `tx_ready_o` stays low and no word starts. This is the state during reset.
- R10: `busy_o` rises after an accepted handshake. It stays high until the final serial clock edge of the last queued word, so every edge of every word occurs while it is high. Queued words follow one another without a gap.
- R11: `rx_valid_o` is a one-cycle pulse per received word, issued with the word's final clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word |
| baud_i | input | BAUD_W | Baud reload value; half period is baud_i+1 cycles |
| tx_data_i | input | DATA_W | Word to transmit, right-aligned |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmit word accepted when high with tx_valid_i |
| rx_data_o | output | DATA_W | Last received word, right-aligned |
| rx_valid_o | output | 1 | One-cycle pulse marking a new received word |
| busy_o | output | 1 | A word is queued or shifting |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Two events can land in the same system clock cycle: the final edge of one word and the start of the queued next word. The final edge also releases `rx_valid_o` for the ending word and reloads the baud counter for the new one. The bench provokes this by offering the next word as soon as the previous one is accepted, so the holding register is always full when a word ends. It judges the result at the pins. Every half period must keep its length across the word boundary. A slave model rebuilds every word from `mosi_o` and supplies `miso_i` bit by bit, so a word that loses, repeats or misorders a bit at the hand-over shows up as a data mismatch or a wrong edge count. This is swept over all lengths, modes, bit orders and loopback settings.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned CTL_TX_OFF = 0;
  localparam int unsigned CTL_RX_OFF = 1;
  localparam int unsigned CTL_MSB    = 4;
  localparam int unsigned CTL_PH     = 5;   // set = phase 0
  localparam int unsigned CTL_POL    = 6;
  localparam int unsigned CTL_LOOP   = 7;
  localparam int unsigned CTL_LEN_LO = 16;
  localparam int unsigned CTL_LEN_W  = 5;
  localparam int unsigned CTL_IDLE   = 23;

  typedef struct packed {
    logic                 tx_on;
    logic                 rx_on;
    logic                 msb_first;
    logic                 cpha;
    logic                 cpol;
    logic                 loop_en;
    logic                 idle_lvl;
    logic [CTL_LEN_W-1:0] len_m1;
  } eng_cfg_t;

  function automatic eng_cfg_t decode_ctl(input logic [31:0] c);
    eng_cfg_t r;
    r.tx_on     = ~c[CTL_TX_OFF];
    r.rx_on     = ~c[CTL_RX_OFF];
    r.msb_first = c[CTL_MSB];
    r.cpha      = ~c[CTL_PH];
    r.cpol      = c[CTL_POL];
    r.loop_en   = c[CTL_LOOP];
    r.idle_lvl  = c[CTL_IDLE];
    r.len_m1    = c[CTL_LEN_LO +: CTL_LEN_W];
    return r;
  endfunction
endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
  parameter int BAUD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] reload_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      reload_q <= baud_i;
      cnt_q    <= baud_i;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - BAUD_W'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == '0);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= reload_q);
  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i) |=> (cnt_q == reload_q));
endmodule

// File: rtl/spi_hold_buf.sv
module spi_hold_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              push_valid_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              push_ready_o,
  input  logic              pop_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign push_ready_o = en_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push_valid_i && push_ready_o) begin
      full_q <= 1'b1;
      data_q <= push_data_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_pop_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> full_q);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !pop_i) |=> full_q);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  eng_cfg_t          cfg_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              end_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int I_W = $clog2(DATA_W);
  localparam int E_W = I_W + 2;

  eng_cfg_t          cfg_q;
  logic              active_q, sclk_q, rxv_q;
  logic [E_W-1:0]    e_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_out_q, rx_next;

  logic [E_W-1:0] len_w, last_e, oe;
  logic [I_W-1:0] lm1, o_idx, o_phys, s_idx, s_phys;
  logic           drive_ok, out_bit, in_bit, smp, end_w;

  assign len_w  = E_W'(cfg_q.len_m1) + E_W'(1);
  assign last_e = {len_w[E_W-2:0], 1'b0} - E_W'(1);
  assign lm1    = I_W'(cfg_q.len_m1);
  // phase 1 presents bit k after edge 2k
  assign oe     = cfg_q.cpha ? e_q - E_W'(1) : e_q;
  assign o_idx  = oe[I_W:1];
  assign s_idx  = e_q[I_W:1];
  assign o_phys = cfg_q.msb_first ? lm1 - o_idx : o_idx;
  assign s_phys = cfg_q.msb_first ? lm1 - s_idx : s_idx;

  assign drive_ok = active_q && !(cfg_q.cpha && e_q == '0);
  assign out_bit  = tx_q[o_phys];
  assign mosi_o   = (drive_ok && cfg_q.tx_on) ? out_bit
                  : (active_q ? cfg_q.idle_lvl : cfg_i.idle_lvl);
  assign in_bit   = cfg_q.loop_en ? mosi_o : miso_i;
  assign smp      = tick_i && (cfg_q.cpha ? e_q[0] : !e_q[0]);
  assign end_w    = tick_i && (e_q == last_e);

  always_comb begin
    rx_next = rx_q;
    if (smp) rx_next[s_phys] = in_bit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      rxv_q    <= 1'b0;
      e_q      <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_out_q <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (tick_i) begin
        sclk_q <= ~sclk_q;
        e_q    <= e_q + E_W'(1);
        rx_q   <= rx_next;
      end
      if (end_w) begin
        active_q <= 1'b0;
        if (cfg_q.rx_on) begin
          rx_out_q <= rx_next;
          rxv_q    <= 1'b1;
        end
      end
      if (start_i) begin
        cfg_q    <= cfg_i;
        active_q <= 1'b1;
        e_q      <= '0;
        tx_q     <= data_i;
        rx_q     <= '0;
        sclk_q   <= cfg_i.cpol;
      end else if (!active_q) begin
        sclk_q <= cfg_i.cpol;
      end
    end
  end

  assign active_o   = active_q;
  assign end_o      = end_w;
  assign sclk_o     = sclk_q;
  assign rx_data_o  = rx_out_q;
  assign rx_valid_o = rxv_q;

  assert_sclk_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i && !start_i) |=> (sclk_q == $past(sclk_q)));
  assert_rxv_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxv_q |=> !rxv_q);
  assert_rxv_rxon_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxv_q |-> ($past(cfg_q.rx_on) && $past(active_q)));
  assert_sclk_rest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> (sclk_q == $past(cfg_q.cpol)));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BAUD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ctrl_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  eng_cfg_t          cfg_live;
  logic              en, buf_full, start, active, word_end, tick;
  logic [DATA_W-1:0] buf_data;
  logic              unused_ctl;

  assign cfg_live   = decode_ctl(ctrl_i);
  assign en         = cfg_live.tx_on || cfg_live.rx_on;
  assign unused_ctl = ^{ctrl_i[31:24], ctrl_i[22:21], ctrl_i[15:8], ctrl_i[3:2]};
  // queued word starts on the final edge of the running one
  assign start      = buf_full && (!active || word_end);
  assign busy_o     = active || buf_full;

  spi_hold_buf #(.DATA_W(DATA_W)) i_hold (
    .clk_i, .rst_ni,
    .en_i        (en),
    .push_valid_i(tx_valid_i),
    .push_data_i (tx_data_i),
    .push_ready_o(tx_ready_o),
    .pop_i       (start),
    .full_o      (buf_full),
    .data_o      (buf_data)
  );

  spi_baud_tick #(.BAUD_W(BAUD_W)) i_baud (
    .clk_i, .rst_ni,
    .load_i(start),
    .run_i (active),
    .baud_i(baud_i),
    .tick_o(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) i_core (
    .clk_i, .rst_ni,
    .start_i   (start),
    .data_i    (buf_data),
    .cfg_i     (cfg_live),
    .tick_i    (tick),
    .miso_i    (miso_i),
    .active_o  (active),
    .end_o     (word_end),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  assert_busy_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> busy_o);
  assert_both_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[CTL_TX_OFF] && ctrl_i[CTL_RX_OFF]) |-> !tx_ready_o);
endmodule

// File: tb/test_spi_shift_engine.sv
`timescale 1ns/1ps
module test_spi_shift_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = 32'h3;
  logic [15:0] baud_i = '0;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [31:0] rx_data_o;
  logic        rx_valid_o, busy_o, sclk_o, mosi_o;
  logic        miso_i = 1'b0;

  spi_shift_engine i_spi_shift_engine (.*);

  always #2.5 clk_i = ~clk_i;

  int errs = 0, checks = 0;
  bit done = 0;

  int cur_len = 8, cur_baud = 0;
  bit cur_cpha = 0, cur_msb = 0, mon_on = 0;
  logic [31:0] miso_pat = '0;
  int e_w = 0, edges_run = 0, edges_tot = 0, half_bad = 0, cyc = 0;
  logic [31:0] cap_w = '0;
  logic [31:0] cap_arr [16];
  logic [31:0] rx_arr [16];
  int n_cap = 0, n_rx = 0;
  logic prev_sclk = 0, prev_mosi = 0, prev_busy = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bpos(input int k);
    return cur_msb ? cur_len - 1 - k : k;
  endfunction

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  task automatic set_miso();
    int idx;
    if (cur_cpha && e_w == 0) miso_i = 1'b0;
    else begin
      idx = cur_cpha ? (e_w - 1) / 2 : e_w / 2;
      miso_i = miso_pat[bpos(idx)];
    end
  endtask

  // slave model and pin monitor
  always @(negedge clk_i) begin
    cyc++;
    if (rx_valid_o && n_rx < 16) begin rx_arr[n_rx] = rx_data_o; n_rx++; end
    if (mon_on && prev_busy && sclk_o != prev_sclk) begin
      if (edges_run > 0 && cyc != cur_baud + 1) half_bad++;
      cyc = 0;
      edges_run++;
      edges_tot++;
      if (e_w[0] == cur_cpha) cap_w[bpos(e_w / 2)] = prev_mosi;
      e_w++;
      if (e_w == 2 * cur_len) begin
        if (n_cap < 16) cap_arr[n_cap] = cap_w;
        n_cap++;
        cap_w = '0;
        e_w = 0;
      end
      set_miso();
    end
    prev_sclk = sclk_o;
    prev_mosi = mosi_o;
    prev_busy = busy_o;
  end

  function automatic logic [31:0] word_of(input int seed, input int k);
    return (seed * 32'h9E37_79B1) ^ (k * 32'h0101_2345) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic run(input int len, input bit cpol, input bit cpha, input bit msb,
                     input bit lb, input bit idle, input bit txoff, input bit rxoff,
                     input int baud, input int nw, input int seed);
    logic [31:0] c, m, idle_w, exp_rx, exp_tx;
    int guard;
    bit acc;
    c = '0;
    c[0] = txoff; c[1] = rxoff; c[4] = msb; c[5] = ~cpha; c[6] = cpol;
    c[7] = lb; c[20:16] = 5'(len - 1); c[23] = idle;
    @(negedge clk_i);
    ctrl_i = c;
    baud_i = 16'(baud);
    cur_len = len; cur_cpha = cpha; cur_msb = msb; cur_baud = baud;
    miso_pat = word_of(seed + 77, 3);
    mon_on = 0;
    repeat (3) @(negedge clk_i);
    e_w = 0; edges_run = 0; edges_tot = 0; half_bad = 0; n_cap = 0; n_rx = 0; cap_w = '0;
    set_miso();
    chk(sclk_o == cpol, "R3 sclk rest level", sclk_o, cpol);
    chk(mosi_o == idle, "R7 mosi idle level", mosi_o, idle);
    mon_on = 1;
    for (int k = 0; k < nw; k++) begin
      tx_data_i = word_of(seed, k);
      tx_valid_i = 1'b1;
      guard = 0;
      do begin
        acc = tx_ready_o;
        @(negedge clk_i);
        guard++;
      end while (!acc && guard < 5000);
    end
    tx_valid_i = 1'b0;
    guard = 0;
    while (busy_o && guard < 20000) begin @(negedge clk_i); guard++; end
    repeat (2) @(negedge clk_i);
    mon_on = 0;
    m = lmask(len);
    idle_w = idle ? m : '0;
    chk(edges_tot == 2 * len * nw, "R1/R10 edge count while busy", edges_tot, 2 * len * nw);
    chk(half_bad == 0, "R2 half period length", half_bad, 0);
    chk(sclk_o == cpol, "R3 sclk after word", sclk_o, cpol);
    chk(mosi_o == idle, "R7 mosi after word", mosi_o, idle);
    chk(n_cap == nw, "R1 words seen on pins", n_cap, nw);
    chk(n_rx == (rxoff ? 0 : nw), "R8/R11 rx pulses", n_rx, rxoff ? 0 : nw);
    for (int k = 0; k < nw && k < 16; k++) begin
      exp_tx = txoff ? idle_w : (word_of(seed, k) & m);
      chk(cap_arr[k] == exp_tx, "R4/R5/R7 mosi word", cap_arr[k], exp_tx);
      if (!rxoff && k < n_rx) begin
        exp_rx = lb ? (txoff ? idle_w : (word_of(seed, k) & m)) : (miso_pat & m);
        chk(rx_arr[k] == exp_rx, lb ? "R6/R1 loopback rx word" : "R4/R5/R1 rx word",
            rx_arr[k], exp_rx);
      end
    end
  endtask

  initial begin
    int lens [9] = '{2, 3, 4, 5, 6, 7, 8, 16, 32};
    bit seen_ready;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0, "R9 reset busy", busy_o, 0);
    chk(rx_valid_o == 0, "R11 reset rx_valid", rx_valid_o, 0);
    chk(sclk_o == 0, "R3 reset sclk", sclk_o, 0);
    chk(tx_ready_o == 0, "R9 reset tx_ready", tx_ready_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    for (int li = 0; li < 9; li++)
      for (int md = 0; md < 4; md++)
        for (int mb = 0; mb < 2; mb++)
          for (int lb = 0; lb < 2; lb++)
            run(lens[li], md[1], md[0], mb[0], lb[0], lb[0] ^ md[0], 0, 0,
                (li + md + mb) % 3, 2, li * 16 + md * 4 + mb * 2 + lb);
    // baud sweep, R2
    for (int b = 0; b < 8; b++) run(8, b[0], b[1], 1, 0, b[2], 0, 0, b, 3, 500 + b);
    // transmitter off, receiver on, R7
    run(8, 0, 0, 1, 0, 1, 1, 0, 1, 2, 900);
    run(16, 1, 1, 0, 1, 0, 1, 0, 0, 2, 901);
    // receiver off, R8
    run(12, 0, 1, 1, 0, 0, 0, 1, 1, 2, 902);
    // both off: handshake refused, R9
    @(negedge clk_i);
    ctrl_i = 32'h0007_0003;
    tx_valid_i = 1'b1;
    tx_data_i = 32'hA5;
    seen_ready = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (tx_ready_o || busy_o) seen_ready = 1;
    end
    tx_valid_i = 1'b0;
    chk(seen_ready == 0, "R9 both off refuses words", seen_ready, 0);
    chk(sclk_o == 0 && mosi_o == 0, "R9 no shifting when both off", {sclk_o, mosi_o}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule